// File: doc/BRIEF.md
# Rank Idle Power-State Controller

This block decides when one DRAM rank may drop its clock enable. It watches a transaction-pending strobe from the scheduler and keeps two idle counters: a short one that leads to power-down, and a longer one that leads to self-refresh. When the short period runs out while the rank is active, a 3-bit mode selection and the bank-open status pick one of three power-down flavours: active, precharge, or precharge with the DLL switched off. When self-refresh is enabled and the long period runs out, the rank goes to self-refresh. It can do so from the active state or from any power-down state. Self-refresh wins when both periods expire in the same cycle.

Any pending transaction clears both idle counts. In a low-power state, it also starts an exit. An exit raises CKE at once and waits through a programmable wake delay. The block then marks the cycle where the rank is usable again with a one-cycle exit-complete pulse and returns to the active state. The short idle limit should be set no lower than the worst round-trip time plus the burst length.

Top module: `rank_lp_ctrl`

## Requirements
- R1: During and right after reset, the state output is 0 (ACTIVE), CKE is high, the DLL-off output is low and the exit-complete pulse is low. State codes: 0 ACTIVE, 1 active power-down, 2 precharge power-down, 3 precharge power-down with DLL off, 4 self-refresh, 5 wake.
- R2: Each idle count goes up by one, saturating, on every clock edge that samples the pending strobe low, and returns to 0 on an edge that samples it high. The state leaves ACTIVE only on an edge that samples the strobe low while the count is at least its limit. A limit of N therefore enters on the (N+1)-th consecutive idle edge.
- R3: Mode codes 0, 4 and 5 never cause power-down entry.
- R4: Mode 1 enters active power-down (1) only when banks are open. Mode 2 enters precharge power-down (2) only when all banks are closed. Mode 3 enters state 1 with banks open and state 2 otherwise.
- R5: Mode 6 enters state 3 only when all banks are closed. Mode 7 enters state 1 with banks open and state 3 otherwise.
- R6: With self-refresh enabled, an idle edge at which the long count is at least its limit moves ACTIVE or any power-down state to self-refresh (4). This takes precedence over power-down entry.
- R7: CKE is low exactly in states 1, 2, 3 and 4.
- R8: The DLL-off output is high exactly in states 3 and 4.
- R9: From states 1 to 4, an edge that samples the strobe high moves to wake (5). So does self-refresh with the enable sampled low.
- R10: Wake lasts wake-delay plus one cycles and ignores the strobe. The exit-complete pulse is high only in its last cycle, after which the state is ACTIVE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| txn_pend_i | input | 1 | A transaction for this rank is pending |
| banks_open_i | input | 1 | At least one bank of the rank is open |
| pd_mode_i | input | 3 | Power-down mode selection |
| pd_idle_i | input | PD_W (8) | Idle cycles before power-down |
| sr_en_i | input | 1 | Self-refresh enable |
| sr_idle_i | input | SR_W (16) | Idle cycles before self-refresh |
| wake_dly_i | input | WAKE_W (4) | Extra cycles spent in wake |
| cke_o | output | 1 | Clock enable to the rank |
| dll_off_o | output | 1 | DLL switched off |
| lp_state_o | output | 3 | Current power state code |
| wake_done_o | output | 1 | Exit-complete pulse |

## Verification
Two kinds of event can land on the same edge. The first is an idle limit being reached on the very edge where a new transaction arrives. The second is both idle limits being reached together. The bench provokes the first by raising the strobe exactly on the expiry edge, and the second by programming equal limits. It judges both with a per-cycle reference model: the state must stay ACTIVE in the first case and go straight to self-refresh in the second. Random phases with bursty strobes and changing modes then hit the same coincidences at other counts.

// File: rtl/rank_lp_pkg.sv
package rank_lp_pkg;

  typedef enum logic [2:0] {
    LP_ACTIVE = 3'd0,
    LP_APD    = 3'd1,
    LP_PPD    = 3'd2,
    LP_PPDOFF = 3'd3,
    LP_SREF   = 3'd4,
    LP_WAKE   = 3'd5
  } lp_state_e;

  typedef enum logic [1:0] {
    PICK_NONE    = 2'd0,
    PICK_ACT     = 2'd1,
    PICK_PRE     = 2'd2,
    PICK_PRE_DLL = 2'd3
  } pd_pick_e;

endpackage

// File: rtl/rank_lp_idle_timer.sv
module rank_lp_idle_timer #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         txn_pend_i,
  input  logic [W-1:0] limit_i,
  output logic [W-1:0] count_o,
  output logic         hit_o
);
  localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = txn_pend_i || (cnt_q != CNT_MAX);
    cnt_d  = txn_pend_i ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign count_o = cnt_q;
  assign hit_o   = (cnt_q >= limit_i);

  assert_idle_clear_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txn_pend_i |=> (count_o == '0));

  assert_idle_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!txn_pend_i && count_o != CNT_MAX) |=> (count_o == $past(count_o) + 1'b1));

  assert_idle_sat_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!txn_pend_i && count_o == CNT_MAX) |=> (count_o == CNT_MAX));

endmodule

// File: rtl/rank_lp_pd_pick.sv
module rank_lp_pd_pick
  import rank_lp_pkg::*;
(
  input  logic     [2:0] mode_i,
  input  logic           banks_open_i,
  output pd_pick_e       pick_o
);
  always_comb begin
    pick_o = PICK_NONE;
    case (mode_i)
      3'd1:    pick_o = banks_open_i ? PICK_ACT  : PICK_NONE;
      3'd2:    pick_o = banks_open_i ? PICK_NONE : PICK_PRE;
      3'd3:    pick_o = banks_open_i ? PICK_ACT  : PICK_PRE;
      3'd6:    pick_o = banks_open_i ? PICK_NONE : PICK_PRE_DLL;
      3'd7:    pick_o = banks_open_i ? PICK_ACT  : PICK_PRE_DLL;
      default: pick_o = PICK_NONE;
    endcase
  end

  always_comb begin
    if (mode_i == 3'd0 || mode_i == 3'd4 || mode_i == 3'd5) begin
      assert_reserved_none_R3: assert (pick_o == PICK_NONE);
    end
  end

endmodule

// File: rtl/rank_lp_fsm.sv
module rank_lp_fsm
  import rank_lp_pkg::*;
#(
  parameter int WAKE_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              txn_pend_i,
  input  logic              pd_hit_i,
  input  logic              sr_hit_i,
  input  logic              sr_en_i,
  input  pd_pick_e          pick_i,
  input  logic [WAKE_W-1:0] wake_dly_i,
  output lp_state_e         state_o,
  output logic              wake_done_o
);
  lp_state_e         st_q, st_d;
  logic [WAKE_W-1:0] wk_q, wk_d;
  logic              sr_go;
  logic              done;

  always_comb begin
    sr_go = sr_en_i && sr_hit_i;
    st_d  = st_q;
    wk_d  = wk_q;
    done  = 1'b0;
    case (st_q)
      LP_ACTIVE: begin
        if (!txn_pend_i) begin
          if (sr_go) begin
            st_d = LP_SREF;
          end else if (pd_hit_i) begin
            case (pick_i)
              PICK_ACT:     st_d = LP_APD;
              PICK_PRE:     st_d = LP_PPD;
              PICK_PRE_DLL: st_d = LP_PPDOFF;
              default:      st_d = LP_ACTIVE;
            endcase
          end
        end
      end
      LP_APD, LP_PPD, LP_PPDOFF: begin
        if (txn_pend_i) begin
          st_d = LP_WAKE;
          wk_d = '0;
        end else if (sr_go) begin
          st_d = LP_SREF;
        end
      end
      LP_SREF: begin
        if (txn_pend_i || !sr_en_i) begin
          st_d = LP_WAKE;
          wk_d = '0;
        end
      end
      LP_WAKE: begin
        if (wk_q >= wake_dly_i) begin
          done = 1'b1;
          st_d = LP_ACTIVE;
        end else begin
          wk_d = wk_q + 1'b1;
        end
      end
      default: st_d = LP_ACTIVE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= LP_ACTIVE;
      wk_q <= '0;
    end else begin
      st_q <= st_d;
      wk_q <= wk_d;
    end
  end

  assign state_o     = st_q;
  assign wake_done_o = done;

  assert_exit_on_txn_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st_q == LP_APD || st_q == LP_PPD || st_q == LP_PPDOFF || st_q == LP_SREF)
     && txn_pend_i) |=> (st_q == LP_WAKE));

  assert_no_entry_busy_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == LP_ACTIVE && txn_pend_i) |=> (st_q == LP_ACTIVE));

  assert_sr_first_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == LP_ACTIVE && !txn_pend_i && sr_en_i && sr_hit_i) |=> (st_q == LP_SREF));

  assert_done_to_active_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_done_o |=> (st_q == LP_ACTIVE));

  assert_wake_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == LP_WAKE && !wake_done_o) |=> (st_q == LP_WAKE));

endmodule

// File: rtl/rank_lp_ctrl.sv
module rank_lp_ctrl
  import rank_lp_pkg::*;
#(
  parameter int PD_W   = 8,
  parameter int SR_W   = 16,
  parameter int WAKE_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              txn_pend_i,
  input  logic              banks_open_i,
  input  logic [2:0]        pd_mode_i,
  input  logic [PD_W-1:0]   pd_idle_i,
  input  logic              sr_en_i,
  input  logic [SR_W-1:0]   sr_idle_i,
  input  logic [WAKE_W-1:0] wake_dly_i,
  output logic              cke_o,
  output logic              dll_off_o,
  output logic [2:0]        lp_state_o,
  output logic              wake_done_o
);
  logic [PD_W-1:0] pd_cnt;
  logic [SR_W-1:0] sr_cnt;
  logic            pd_hit, sr_hit;
  pd_pick_e        pick;
  lp_state_e       state;

  rank_lp_idle_timer #(.W(PD_W)) u_pd_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .txn_pend_i (txn_pend_i),
    .limit_i    (pd_idle_i),
    .count_o    (pd_cnt),
    .hit_o      (pd_hit)
  );

  rank_lp_idle_timer #(.W(SR_W)) u_sr_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .txn_pend_i (txn_pend_i),
    .limit_i    (sr_idle_i),
    .count_o    (sr_cnt),
    .hit_o      (sr_hit)
  );

  rank_lp_pd_pick u_pick (
    .mode_i       (pd_mode_i),
    .banks_open_i (banks_open_i),
    .pick_o       (pick)
  );

  rank_lp_fsm #(.WAKE_W(WAKE_W)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .txn_pend_i  (txn_pend_i),
    .pd_hit_i    (pd_hit),
    .sr_hit_i    (sr_hit),
    .sr_en_i     (sr_en_i),
    .pick_i      (pick),
    .wake_dly_i  (wake_dly_i),
    .state_o     (state),
    .wake_done_o (wake_done_o)
  );

  always_comb begin
    cke_o     = !(state == LP_APD || state == LP_PPD || state == LP_PPDOFF || state == LP_SREF);
    dll_off_o = (state == LP_PPDOFF || state == LP_SREF);
  end

  assign lp_state_o = state;

  assert_reserved_stay_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == LP_ACTIVE && !(sr_en_i && sr_hit) &&
     (pd_mode_i == 3'd0 || pd_mode_i == 3'd4 || pd_mode_i == 3'd5))
    |=> (lp_state_o == 3'd0));

  assert_cke_rise_on_exit_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cke_o && txn_pend_i) |=> cke_o);

  assert_dll_only_lowcke_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dll_off_o |-> !cke_o);

endmodule

// File: tb/tb_rank_lp_ctrl.sv
module tb_rank_lp_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n;
  logic        txn, banks;
  logic [2:0]  mode;
  logic [7:0]  pd_idle;
  logic        sr_en;
  logic [15:0] sr_idle;
  logic [3:0]  wdly;
  logic        cke, dll_off, wdone;
  logic [2:0]  st;

  int total = 0;
  int bad = 0;
  int m_st, m_pd, m_sr, m_wk;
  string cur_tag = "R4";

  rank_lp_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .txn_pend_i(txn), .banks_open_i(banks),
    .pd_mode_i(mode), .pd_idle_i(pd_idle), .sr_en_i(sr_en), .sr_idle_i(sr_idle),
    .wake_dly_i(wdly), .cke_o(cke), .dll_off_o(dll_off), .lp_state_o(st),
    .wake_done_o(wdone)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Target state from mode and bank status (R3, R4, R5); 0 means none
  function automatic int pick_target(input int md, input bit open);
    case (md)
      1: return open ? 1 : 0;
      2: return open ? 0 : 2;
      3: return open ? 1 : 2;
      6: return open ? 0 : 3;
      7: return open ? 1 : 3;
      default: return 0;
    endcase
  endfunction

  function automatic bit exp_cke(input int s);
    return !(s >= 1 && s <= 4);
  endfunction

  function automatic bit exp_dll(input int s);
    return (s == 3 || s == 4);
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic check_all();
    check(cur_tag, "state", int'(st), m_st);
    check("R7", "cke", int'(cke), int'(exp_cke(m_st)));
    check("R8", "dll_off", int'(dll_off), int'(exp_dll(m_st)));
    check("R10", "wake_done", int'(wdone), int'(m_st == 5 && m_wk >= int'(wdly)));
  endtask

  // One clock: advance the model at the edge, then compare at the falling edge
  task automatic tick();
    int nx, tg;
    bit srgo, pdh;
    @(posedge clk);
    srgo = sr_en && (m_sr >= int'(sr_idle));
    pdh  = (m_pd >= int'(pd_idle));
    nx = m_st;
    case (m_st)
      0: if (!txn) begin
           tg = pick_target(int'(mode), banks);
           if (srgo) nx = 4;
           else if (pdh && tg != 0) nx = tg;
         end
      1, 2, 3: if (txn) begin nx = 5; m_wk = 0; end
               else if (srgo) nx = 4;
      4: if (txn || !sr_en) begin nx = 5; m_wk = 0; end
      5: if (m_wk >= int'(wdly)) nx = 0; else m_wk++;
      default: nx = 0;
    endcase
    m_st = nx;
    if (txn) begin m_pd = 0; m_sr = 0; end
    else begin
      if (m_pd < 255) m_pd++;
      if (m_sr < 65535) m_sr++;
    end
    @(negedge clk);
    check_all();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin txn = 1'b0; tick(); end
  endtask

  task automatic busy(input int n);
    for (int i = 0; i < n; i++) begin txn = 1'b1; tick(); end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int seed, prob, len;
    seed = int'($urandom(32'd20240611));
    rst_n = 1'b0; txn = 1'b0; banks = 1'b0; mode = 3'd0; pd_idle = 8'd4;
    sr_en = 1'b0; sr_idle = 16'd20; wdly = 4'd2;
    m_st = 0; m_pd = 0; m_sr = 0; m_wk = 0;
    repeat (3) @(negedge clk);
    cur_tag = "R1";
    check_all();
    rst_n = 1'b1;
    busy(2);

    // R4: combined mode follows banks_open; exact entry cycle of R2
    cur_tag = "R4"; mode = 3'd3; banks = 1'b1; pd_idle = 8'd4;
    idle(8);
    check("R4", "apd entered", int'(st), 1);
    cur_tag = "R9"; busy(1);
    check("R9", "wake after txn", int'(st), 5);
    cur_tag = "R10"; idle(4);
    banks = 1'b0; cur_tag = "R4"; busy(1); idle(7);
    check("R4", "ppd entered", int'(st), 2);
    busy(1); idle(4);

    // R2: new transaction exactly on the expiry edge keeps ACTIVE
    cur_tag = "R2"; mode = 3'd2; pd_idle = 8'd3;
    busy(1); idle(3); busy(1);
    check("R2", "txn on expiry edge", int'(st), 0);
    idle(1); idle(3);
    check("R2", "entry after limit", int'(st), 2);
    busy(1); idle(3);
    pd_idle = 8'd0; busy(1); idle(1);
    check("R2", "zero limit entry", int'(st), 2);
    busy(1); idle(3);

    // R6: both limits reached together -> self-refresh wins
    cur_tag = "R6"; sr_en = 1'b1; sr_idle = 16'd5; pd_idle = 8'd5;
    busy(1); idle(6);
    check("R6", "sref precedence", int'(st), 4);
    check("R8", "dll off in sref", int'(dll_off), 1);
    cur_tag = "R9"; sr_en = 1'b0; tick();
    check("R9", "sref exit on disable", int'(st), 5);
    idle(3);

    // R6: power-down first, then self-refresh on top
    cur_tag = "R6"; sr_en = 1'b1; sr_idle = 16'd12; pd_idle = 8'd3; mode = 3'd1; banks = 1'b1;
    busy(1); idle(5);
    check("R6", "apd before sref", int'(st), 1);
    idle(10);
    check("R6", "apd to sref", int'(st), 4);
    busy(1); idle(3); sr_en = 1'b0;

    // R3: reserved and zero modes never power down
    cur_tag = "R3";
    for (int k = 0; k < 3; k++) begin
      mode = (k == 0) ? 3'd0 : ((k == 1) ? 3'd4 : 3'd5);
      busy(1); idle(30);
      check("R3", "reserved mode stays active", int'(st), 0);
    end

    // R5: DLL-off modes
    cur_tag = "R5"; mode = 3'd7; banks = 1'b0; pd_idle = 8'd2;
    busy(1); idle(4);
    check("R5", "mode7 closed", int'(st), 3);
    check("R8", "dll_off in ppd dll", int'(dll_off), 1);
    busy(1); idle(3);
    mode = 3'd6; banks = 1'b1; busy(1); idle(6);
    check("R5", "mode6 open stays", int'(st), 0);
    banks = 1'b0; idle(1);
    check("R5", "mode6 closed", int'(st), 3);
    busy(1); idle(3);

    // R10: long wake ignores strobe
    cur_tag = "R10"; mode = 3'd2; wdly = 4'd7; pd_idle = 8'd1;
    idle(3); busy(1);
    busy(5);
    check("R10", "wake ignores txn", int'(st), 5);
    busy(4);

    // Random phases
    cur_tag = "R4";
    for (int ep = 0; ep < 250; ep++) begin
      mode    = 3'($urandom_range(0, 7));
      banks   = 1'($urandom_range(0, 1));
      pd_idle = 8'($urandom_range(0, 12));
      sr_en   = 1'($urandom_range(0, 1));
      sr_idle = 16'($urandom_range(0, 40));
      wdly    = 4'($urandom_range(0, 5));
      case ($urandom_range(0, 2))
        0: prob = 0;
        1: prob = 5;
        default: prob = 50;
      endcase
      len = $urandom_range(20, 120);
      for (int c = 0; c < len; c++) begin
        txn = ($urandom_range(0, 99) < prob);
        if ($urandom_range(0, 49) == 0) banks = ~banks;
        tick();
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule